// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns one debounced GPIO input into an interrupt source. A per-pin control word chooses the trigger: level or edge detection, and one of three polarity codes (low or falling, high or rising, both edges). Matching events are caught in a sticky interrupt status bit. A separate wake status bit latches events when wake detection is on. Software clears either status bit by writing a 1 to it.

The interrupt enable decides whether events latch into the status bit. The unmask bit is a separate control: it decides only whether a latched interrupt status reaches the summary output. Wake status always reaches the summary output. Turning an interrupt off therefore means clearing both enable and unmask. Masking alone keeps detection running, so pending events are not lost.

Software reaches the block through one 32-bit control/status word. The word is read back as it is. A write updates the configuration and clears any status bit written as 1. Writing back a value that was just read therefore clears whatever was pending. The bus that carries the word sits outside the block.

Top module: `gpio_irq_pin`

## Requirements
- R1: After reset, every configuration field and both status bits read 0, and `irq_out` is 0.
- R2: Word layout: bit 0 selects the trigger (1 = level, 0 = edge). Bits 2:1 hold the polarity code. Bit 3 is interrupt enable, bit 4 is unmask (1 = passes), and bit 5 is wake enable. Bit 8 is read-only and gives the pin level sampled at the last clock. Bit 12 is interrupt status and bit 13 is wake status. All other bits read 0.
- R3: In edge mode, polarity code 01 sets interrupt status on a 0-to-1 transition of the pin and not on a 1-to-0 transition.
- R4: In edge mode, polarity code 00 sets interrupt status on a 1-to-0 transition and not on a 0-to-1 transition.
- R5: In edge mode, polarity code 10 sets interrupt status on either transition.
- R6: Polarity code 11 never sets a status bit, in either edge or level mode. In level mode, code 10 also never sets a status bit.
- R7: In level mode, code 01 sets status while the pin is 1 and code 00 sets it while the pin is 0. The bit sets again on every cycle the level persists, so a clear written while the level is still active leaves it set.
- R8: With interrupt enable at 0, no event sets interrupt status and `irq_out` stays 0.
- R9: With unmask at 0, interrupt status still latches but does not drive `irq_out`. Setting unmask later forwards the pending status.
- R10: Writing 1 to bit 12 or bit 13 clears that status bit, and writing 0 leaves it unchanged. Writing back a value just read clears the pending status.
- R11: When a detection event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R12: With wake enable at 1, a detection event sets wake status regardless of interrupt enable. Wake status drives `irq_out` regardless of unmask.
- R13: `irq_out` is registered. It equals (interrupt status AND unmask) OR wake status, as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 1 | Debounced pin level |
| reg_wr | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | REG_W | Write data: configuration, and 1s that clear status bits |
| reg_rdata | output | REG_W | Current control/status word |
| irq_out | output | 1 | Summary interrupt contribution of this pin |

## Verification
The bench builds the block with REG_W = 32 and IRQ_OUT_REG = 1. This is the register-word width software sees and the registered summary path, so the one-cycle gap between a status bit setting and `irq_out` rising can be observed directly. With these values every polarity code can be reached in both trigger modes, including the reserved code. The bench also reaches the write-back-of-read clear and the cycle in which a new event meets a clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Polarity code; the encoding is software-visible.
  typedef enum logic [1:0] {
    POL_LOW  = 2'b00,
    POL_HIGH = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } pol_e;

  typedef struct packed {
    logic level;
    pol_e pol;
    logic ien;
    logic unmask;
    logic wen;
  } irq_cfg_t;

  // Field positions in the control/status word.
  localparam int FLD_LEVEL  = 0;
  localparam int FLD_POL    = 1;
  localparam int FLD_IEN    = 3;
  localparam int FLD_UNMASK = 4;
  localparam int FLD_WEN    = 5;
  localparam int FLD_PIN    = 8;
  localparam int FLD_ISTS   = 12;
  localparam int FLD_WSTS   = 13;
  localparam int FLD_TOP    = FLD_WSTS;

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output irq_cfg_t         cfg_o,
  output logic             clr_int,
  output logic             clr_wake
);

  irq_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.level  <= wdata[FLD_LEVEL];
      cfg_q.pol    <= pol_e'(wdata[FLD_POL +: 2]);
      cfg_q.ien    <= wdata[FLD_IEN];
      cfg_q.unmask <= wdata[FLD_UNMASK];
      cfg_q.wen    <= wdata[FLD_WEN];
    end
  end

  assign cfg_o    = cfg_q;
  assign clr_int  = wr_en & wdata[FLD_ISTS];
  assign clr_wake = wr_en & wdata[FLD_WSTS];

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  // R2: without a write the configuration holds
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pin_in,
  input  irq_cfg_t cfg,
  output logic     pin_q,
  output logic     event_o
);

  logic rise, fall, lvl_hit, edge_hit;

  // Tracks the pin even in reset so no false edge follows reset release.
  always_ff @(posedge clk) begin
    pin_q <= pin_in;
  end

  assign rise = pin_in & ~pin_q;
  assign fall = ~pin_in & pin_q;

  always_comb begin
    unique case (cfg.pol)
      POL_LOW:  lvl_hit = ~pin_in;
      POL_HIGH: lvl_hit = pin_in;
      default:  lvl_hit = 1'b0;
    endcase
    unique case (cfg.pol)
      POL_LOW:  edge_hit = fall;
      POL_HIGH: edge_hit = rise;
      POL_BOTH: edge_hit = rise | fall;
      default:  edge_hit = 1'b0;
    endcase
  end

  assign event_o = cfg.level ? lvl_hit : edge_hit;

  // R6: the reserved code stays silent
  assert_rsvd_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg.pol == POL_RSVD) |-> !event_o);

  // R3: no event while the pin is steady in edge mode
  assert_edge_steady_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg.level && pin_in == pin_q) |-> !event_o);

endmodule

// File: rtl/gpio_irq_sticky.sv
module gpio_irq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);

  logic sts_q;

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (rst) sts_q <= 1'b0;
    else     sts_q <= (sts_q & ~clr_i) | set_i;
  end

  assign sts_o = sts_q;

  // R11: set beats a simultaneous clear
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    set_i |=> sts_q);

  // R10: a clear without a set empties the bit
  assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !sts_q);

  // R10: a pending bit holds until cleared
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (sts_q && !clr_i) |=> sts_q);

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter bit IRQ_OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_out
);

  localparam int PAD_W = REG_W - FLD_TOP - 1;

  irq_cfg_t cfg;
  logic     clr_int, clr_wake;
  logic     pin_q, det_event;
  logic     int_sts, wake_sts;
  logic     irq_next;

  gpio_irq_cfg #(.REG_W(REG_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .wdata   (reg_wdata),
    .cfg_o   (cfg),
    .clr_int (clr_int),
    .clr_wake(clr_wake)
  );

  gpio_irq_detect u_det (
    .clk    (clk),
    .rst    (rst),
    .pin_in (pin_in),
    .cfg    (cfg),
    .pin_q  (pin_q),
    .event_o(det_event)
  );

  gpio_irq_sticky u_int_sts (
    .clk  (clk),
    .rst  (rst),
    .set_i(det_event & cfg.ien),
    .clr_i(clr_int),
    .sts_o(int_sts)
  );

  gpio_irq_sticky u_wake_sts (
    .clk  (clk),
    .rst  (rst),
    .set_i(det_event & cfg.wen),
    .clr_i(clr_wake),
    .sts_o(wake_sts)
  );

  assign irq_next = (int_sts & cfg.unmask) | wake_sts;

  generate
    if (IRQ_OUT_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_next;
      end
      assign irq_out = irq_q;

      // R13: nothing pending means a quiet line next cycle
      assert_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        (!int_sts && !wake_sts) |=> !irq_out);

      // R12: wake status passes regardless of the mask
      assert_wake_irq_R12: assert property (@(posedge clk) disable iff (rst)
        wake_sts |=> irq_out);
    end else begin : g_irq_comb
      assign irq_out = irq_next;
    end
  endgenerate

  always_comb begin
    reg_rdata                 = '0;
    reg_rdata[FLD_LEVEL]      = cfg.level;
    reg_rdata[FLD_POL +: 2]   = cfg.pol;
    reg_rdata[FLD_IEN]        = cfg.ien;
    reg_rdata[FLD_UNMASK]     = cfg.unmask;
    reg_rdata[FLD_WEN]        = cfg.wen;
    reg_rdata[FLD_PIN]        = pin_q;
    reg_rdata[FLD_ISTS]       = int_sts;
    reg_rdata[FLD_WSTS]       = wake_sts;
    if (PAD_W > 0) reg_rdata[REG_W-1:FLD_TOP+1] = '0;
  end

  // R8: a disabled interrupt never latches
  assert_no_latch_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg.ien && !int_sts) |=> !int_sts);

  // R7: an active level keeps the status set
  assert_level_persist_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg.level && cfg.ien && cfg.pol == POL_HIGH && pin_in) |=> int_sts);

endmodule

// File: tb/tb_gpio_irq_pin.sv
module tb_gpio_irq_pin;

  localparam int W = 32;
  localparam logic [W-1:0] CLR_I = 32'h1000;
  localparam logic [W-1:0] CLR_W = 32'h2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic wr = 1'b0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] rd;
  logic irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_pin #(.REG_W(W), .IRQ_OUT_REG(1'b1)) dut (
    .clk(clk), .rst(rst), .pin_in(pin), .reg_wr(wr),
    .reg_wdata(wd), .reg_rdata(rd), .irq_out(irq)
  );

  function automatic logic [W-1:0] mk(input bit lvl, input bit [1:0] pol,
                                      input bit ien, input bit unm, input bit wen);
    return W'({wen, unm, ien, pol, lvl});
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wreg(input logic [W-1:0] d);
    @(negedge clk); wr = 1'b1; wd = d;
    @(negedge clk); wr = 1'b0; wd = '0;
  endtask

  task automatic setpin(input logic v);
    @(negedge clk); pin = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rdata", rd, '0);
    chk("R1 irq", W'(irq), '0);
  endtask

  task automatic t_layout();
    wreg(mk(1, 2'b10, 1, 1, 1));
    chk("R2 fields", rd, 32'h3D);
    setpin(1'b1);
    chk("R2 pin bit", rd, 32'h13D);
    wreg('0);
    setpin(1'b0);
    chk("R2 cleared", rd, '0);
  endtask

  task automatic t_rise();
    wreg(mk(0, 2'b01, 1, 1, 0));
    setpin(1'b1);
    chk("R3 rise sets", W'(rd[12]), 1);
    chk("R13 irq lags status", W'(irq), 0);
    step();
    chk("R13 irq follows", W'(irq), 1);
    wreg(mk(0, 2'b01, 1, 1, 0) | CLR_I);
    chk("R3 cleared", W'(rd[12]), 0);
    step();
    chk("R13 irq drops", W'(irq), 0);
    setpin(1'b0);
    chk("R3 fall ignored", W'(rd[12]), 0);
  endtask

  task automatic t_fall();
    wreg(mk(0, 2'b00, 1, 1, 0));
    setpin(1'b1);
    chk("R4 rise ignored", W'(rd[12]), 0);
    setpin(1'b0);
    chk("R4 fall sets", W'(rd[12]), 1);
    wreg(mk(0, 2'b00, 1, 1, 0) | CLR_I);
  endtask

  task automatic t_both();
    wreg(mk(0, 2'b10, 1, 1, 0));
    setpin(1'b1);
    chk("R5 rise sets", W'(rd[12]), 1);
    wreg(mk(0, 2'b10, 1, 1, 0) | CLR_I);
    chk("R5 clear", W'(rd[12]), 0);
    setpin(1'b0);
    chk("R5 fall sets", W'(rd[12]), 1);
    wreg(mk(0, 2'b10, 1, 1, 0) | CLR_I);
  endtask

  task automatic t_rsvd();
    wreg(mk(0, 2'b11, 1, 1, 1));
    setpin(1'b1);
    setpin(1'b0);
    chk("R6 edge rsvd", W'(rd[13:12]), 0);
    wreg(mk(1, 2'b11, 1, 1, 1));
    setpin(1'b1);
    step();
    chk("R6 level rsvd", W'(rd[13:12]), 0);
    wreg(mk(1, 2'b10, 1, 1, 1));
    step();
    chk("R6 level both-code", W'(rd[13:12]), 0);
    chk("R6 irq quiet", W'(irq), 0);
    wreg('0);
    setpin(1'b0);
  endtask

  task automatic t_level();
    wreg(mk(1, 2'b01, 1, 1, 0));
    setpin(1'b1);
    chk("R7 high sets", W'(rd[12]), 1);
    wreg(mk(1, 2'b01, 1, 1, 0) | CLR_I);
    chk("R7 re-sets after clear", W'(rd[12]), 1);
    setpin(1'b0);
    wreg(mk(1, 2'b01, 1, 1, 0) | CLR_I);
    chk("R7 clear once inactive", W'(rd[12]), 0);
    wreg(mk(1, 2'b00, 1, 1, 0));
    step();
    chk("R7 low sets", W'(rd[12]), 1);
    setpin(1'b1);
    wreg(mk(1, 2'b00, 1, 1, 0) | CLR_I);
    chk("R7 low clear", W'(rd[12]), 0);
    wreg('0);
    setpin(1'b0);
  endtask

  task automatic t_disable();
    wreg(mk(0, 2'b01, 0, 1, 0));
    setpin(1'b1);
    step();
    chk("R8 no latch", W'(rd[12]), 0);
    chk("R8 irq quiet", W'(irq), 0);
    setpin(1'b0);
  endtask

  task automatic t_mask();
    wreg(mk(0, 2'b01, 1, 0, 0));
    setpin(1'b1);
    step();
    chk("R9 latched masked", W'(rd[12]), 1);
    chk("R9 masked irq", W'(irq), 0);
    wreg(mk(0, 2'b01, 1, 1, 0));
    step();
    chk("R9 unmask forwards", W'(irq), 1);
    wreg(mk(0, 2'b01, 1, 1, 0) | CLR_I);
    setpin(1'b0);
  endtask

  task automatic t_w1c();
    logic [W-1:0] snap;
    wreg(mk(0, 2'b01, 1, 1, 0));
    setpin(1'b1);
    wreg(mk(0, 2'b01, 1, 1, 0));
    chk("R10 zero keeps", W'(rd[12]), 1);
    snap = rd;
    wreg(snap);
    chk("R10 write-back clears", W'(rd[12]), 0);
    chk("R10 config kept", rd & 32'h3F, mk(0, 2'b01, 1, 1, 0));
    setpin(1'b0);
  endtask

  task automatic t_same();
    wreg(mk(0, 2'b01, 1, 1, 0));
    @(negedge clk);
    pin = 1'b1; wr = 1'b1; wd = mk(0, 2'b01, 1, 1, 0) | CLR_I;
    @(negedge clk);
    wr = 1'b0; wd = '0;
    chk("R11 set wins", W'(rd[12]), 1);
    wreg(mk(0, 2'b01, 1, 1, 0) | CLR_I);
    setpin(1'b0);
  endtask

  task automatic t_wake();
    wreg(mk(0, 2'b01, 0, 0, 1));
    setpin(1'b1);
    chk("R12 wake sets", W'(rd[13:12]), 2);
    step();
    chk("R12 wake irq unmasked-free", W'(irq), 1);
    wreg(mk(0, 2'b01, 0, 0, 1) | CLR_W);
    chk("R12 wake clear", W'(rd[13]), 0);
    step();
    chk("R12 irq drops", W'(irq), 0);
    wreg('0);
    setpin(1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_layout();
    t_rise();
    t_fall();
    t_both();
    t_rsvd();
    t_level();
    t_disable();
    t_mask();
    t_w1c();
    t_same();
    t_wake();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule